// File: doc/BRIEF.md
# Indexed Colour Palette with Sequential Load Port

This block holds the colour table of an 8-bit indexed framebuffer. Each of its entries carries an 8-bit red, green and blue value. Software loads the table through two bus registers. A pointer register selects the entry to fill. A colour-map register then accepts colour bytes one after another. A small phase counter decides whether each byte is red, green or blue. After the blue byte, the pointer moves to the next entry on its own, so a whole table can be streamed with one pointer write followed by data writes.

The data register takes single-byte writes and full 32-bit writes. A full-word write is unpacked into four bytes, most significant first, and each byte moves the phase on. The phase therefore carries across entries and across writes: the fourth byte of a word starts the next entry.

The display side has its own read port. It turns a pixel index into a packed 24-bit colour one cycle later, and it keeps working while the bus is loading the table. Every accepted colour-map write raises a one-cycle `redraw` pulse, which asks the display path to refresh the whole screen.

Top module: `palette_lut`

## Requirements
- R1: A write to offset 0x0 (byte form or word form) loads the entry pointer from `bus_wdata[7:0]` and returns the phase to red.
- R2: A byte-form write (`bus_be` = 4'b0001) to offset 0x4 stores `bus_wdata[7:0]` into one component of the pointed entry. The phase chooses the component: red (0), then green (1), then blue (2).
- R3: Storing a blue byte advances the pointer by one, modulo 256 (0xFF wraps to 0x00), and returns the phase to red.
- R4: A word-form write (`bus_be` = 4'b1111) to offset 0x4 is taken as four bytes in the order bits 31:24, 23:16, 15:8, 7:0. Each byte is stored and advances the phase exactly as a byte-form write would, so the fourth byte lands in the entry after the one holding the first byte.
- R5: Any other `bus_be` pattern, and any offset other than 0x0 and 0x4, leaves the table, the pointer, the phase and `redraw` unchanged.
- R6: `bus_rdata` is zero for every offset.
- R7: Reset makes every entry read as zero, sets the pointer to 0x00 and sets the phase to red.
- R8: `pix_rgb` shows the entry selected by `pix_idx` on the cycle after the index is sampled, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R9: If the lookup port samples an entry in the same cycle that a bus write changes it, the lookup returns the value from before the write.
- R10: `redraw` is high for exactly the one cycle after each accepted colour-map write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_be | input | 4 | Byte-lane enables; 4'b0001 means byte form, 4'b1111 means word form |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, always zero |
| redraw | output | 1 | One-cycle pulse after a colour-map write |
| pix_idx | input | 8 | Pixel index for lookup |
| pix_rgb | output | 24 | Looked-up colour {R,G,B} |

## Verification
The bench uses the default parameters: a 256-entry table, 8-bit components and a 32-bit bus. With these values a four-byte word writes the same component twice (at the current entry and at the next). The pointer wrap from 0xFF to 0x00 can be reached in a single word write. Word writes are exercised from each of the three starting phases. The bench also checks a write and a lookup on the same entry in the same cycle, and a reset taken mid-sequence, after which every entry is read back as zero.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int REG_INDEX_OFS = 0;
  localparam int REG_CMAP_OFS  = 4;
  localparam int NUM_COMP      = 3;
endpackage

// File: rtl/palette_bank.sv
// One component bank: registered read (old data on collision), and
// per-entry valid bits so reset clears contents without touching the RAM.
module palette_bank #(
  parameter int AW = 7,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    rd_q;
  logic             rv_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      rv_q <= 1'b0;
    end else begin
      if (we) vld[waddr] <= 1'b1;
      rv_q <= vld[raddr];
    end
  end

  assign rdata = rv_q ? rd_q : '0;
endmodule

// File: rtl/palette_wr_seq.sv
// Bus decoder and phase/pointer sequencer. Unpacks a write into byte slots,
// each tagged with its component and target entry.
module palette_wr_seq
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int CW     = 8,
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  localparam int NB    = DATA_W / CW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_we,
  input  logic [AW-1:0]             bus_addr,
  input  logic [NB-1:0]             bus_be,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [NB-1:0]             slot_vld,
  output logic [NB-1:0][1:0]        slot_comp,
  output logic [NB-1:0][IDX_W-1:0]  slot_ent,
  output logic [NB-1:0][CW-1:0]     slot_dat,
  output logic [IDX_W-1:0]          cur_idx,
  output phase_e                    cur_phase,
  output logic                      redraw
);
  localparam int SW = $clog2(NB + NUM_COMP) + 1;

  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;
  logic             redraw_q;
  logic             form_byte, form_word, idx_hit, cmap_hit;
  logic [SW-1:0]    tot;

  assign form_byte = (bus_be == NB'(1));
  assign form_word = (bus_be == '1);
  assign idx_hit   = bus_we && (bus_addr == AW'(REG_INDEX_OFS)) && (form_byte || form_word);
  assign cmap_hit  = bus_we && (bus_addr == AW'(REG_CMAP_OFS))  && (form_byte || form_word);

  always_comb begin
    logic [SW-1:0] ph_sum;
    for (int k = 0; k < NB; k++) begin
      ph_sum       = SW'(phase_q) + SW'(k);
      slot_vld[k]  = cmap_hit && (form_word || (k == 0));
      slot_dat[k]  = form_word ? bus_wdata[(NB-1-k)*CW +: CW] : bus_wdata[CW-1:0];
      slot_comp[k] = 2'(ph_sum % SW'(NUM_COMP));
      slot_ent[k]  = idx_q + IDX_W'(ph_sum / SW'(NUM_COMP));
    end
  end

  assign tot = SW'(phase_q) + (form_word ? SW'(NB) : SW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      phase_q  <= PH_RED;
      redraw_q <= 1'b0;
    end else begin
      redraw_q <= cmap_hit;
      if (idx_hit) begin
        idx_q   <= bus_wdata[IDX_W-1:0];
        phase_q <= PH_RED;
      end else if (cmap_hit) begin
        idx_q   <= idx_q + IDX_W'(tot / SW'(NUM_COMP));
        phase_q <= phase_e'(2'(tot % SW'(NUM_COMP)));
      end
    end
  end

  assign cur_idx   = idx_q;
  assign cur_phase = phase_q;
  assign redraw    = redraw_q;
endmodule

// File: rtl/palette_lut.sv
// Palette top: three components, each split into even/odd entry banks so a
// word write may touch one component at two neighbouring entries at once.
module palette_lut
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int CW     = 8,
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  localparam int NB    = DATA_W / CW,
  localparam int HAW   = IDX_W - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [NB-1:0]          bus_be,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   redraw,
  input  logic [IDX_W-1:0]       pix_idx,
  output logic [NUM_COMP*CW-1:0] pix_rgb
);
  logic [NB-1:0]            slot_vld;
  logic [NB-1:0][1:0]       slot_comp;
  logic [NB-1:0][IDX_W-1:0] slot_ent;
  logic [NB-1:0][CW-1:0]    slot_dat;
  logic [IDX_W-1:0]         cur_idx;
  phase_e                   cur_phase;
  logic                     par_q;
  logic [CW-1:0]            bank_q [NUM_COMP][2];

  palette_wr_seq #(
    .IDX_W(IDX_W), .CW(CW), .DATA_W(DATA_W), .AW(AW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .slot_vld  (slot_vld),
    .slot_comp (slot_comp),
    .slot_ent  (slot_ent),
    .slot_dat  (slot_dat),
    .cur_idx   (cur_idx),
    .cur_phase (cur_phase),
    .redraw    (redraw)
  );

  always_ff @(posedge clk) begin
    if (rst) par_q <= 1'b0;
    else     par_q <= pix_idx[0];
  end

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    for (genvar q = 0; q < 2; q++) begin : g_par
      logic           we;
      logic [HAW-1:0] wa;
      logic [CW-1:0]  wd;

      always_comb begin
        we = 1'b0;
        wa = '0;
        wd = '0;
        for (int k = 0; k < NB; k++) begin
          if (slot_vld[k] && (slot_comp[k] == 2'(c)) && (slot_ent[k][0] == 1'(q))) begin
            we = 1'b1;
            wa = slot_ent[k][IDX_W-1:1];
            wd = slot_dat[k];
          end
        end
      end

      palette_bank #(.AW(HAW), .DW(CW)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (wa),
        .wdata (wd),
        .raddr (pix_idx[IDX_W-1:1]),
        .rdata (bank_q[c][q])
      );
    end
    assign pix_rgb[(NUM_COMP-1-c)*CW +: CW] = par_q ? bank_q[c][1] : bank_q[c][0];
  end

  assign bus_rdata = '0;
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int NB    = 4,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NB-1:0]    bus_be,
  input logic [IDX_W-1:0] idx_data,
  input logic             redraw,
  input logic [IDX_W-1:0] cur_idx,
  input logic [1:0]       cur_phase
);
  logic fb, fw, idx_wr, cmap_wr;
  assign fb      = (bus_be == NB'(1));
  assign fw      = (bus_be == '1);
  assign idx_wr  = bus_we && (bus_addr == AW'(REG_INDEX_OFS)) && (fb || fw);
  assign cmap_wr = bus_we && (bus_addr == AW'(REG_CMAP_OFS))  && (fb || fw);

  p_index_load_r1: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> (cur_idx == $past(idx_data)) && (cur_phase == 2'(PH_RED)));

  p_byte_phase_r2: assert property (@(posedge clk) disable iff (rst)
    (cmap_wr && fb && cur_phase != 2'(PH_BLU)) |=>
      (cur_idx == $past(cur_idx)) && (cur_phase == $past(cur_phase) + 2'd1));

  p_blue_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cmap_wr && fb && cur_phase == 2'(PH_BLU)) |=>
      (cur_idx == $past(cur_idx) + 1'b1) && (cur_phase == 2'(PH_RED)));

  p_word_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (cmap_wr && fw) |=> (cur_phase == 2'((32'($past(cur_phase)) + NB) % NUM_COMP)));

  p_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !idx_wr && !cmap_wr) |=> ($stable(cur_idx) && $stable(cur_phase) && !redraw));

  p_reset_state_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cur_idx == '0) && (cur_phase == 2'(PH_RED)));

  p_redraw_set_r10: assert property (@(posedge clk) disable iff (rst)
    cmap_wr |=> redraw);

  p_redraw_clr_r10: assert property (@(posedge clk) disable iff (rst)
    !cmap_wr |=> !redraw);
endmodule

bind palette_lut palette_lut_chk #(.IDX_W(IDX_W), .NB(NB), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .idx_data  (bus_wdata[IDX_W-1:0]),
  .redraw    (redraw),
  .cur_idx   (cur_idx),
  .cur_phase (cur_phase)
);

// File: tb/palette_lut_test.sv
module palette_lut_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        redraw;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  palette_lut uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .redraw(redraw), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  // {req, addr, be, data, check index, expected rgb, expected redraw}
  localparam int NV = 14;
  localparam logic [77:0] VEC [NV] = '{
    {4'd1,  5'h00, 4'hF, 32'h0000_0010, 8'h10, 24'h000000, 1'b0}, // R1 word-form pointer
    {4'd2,  5'h04, 4'h1, 32'h0000_0011, 8'h10, 24'h110000, 1'b1}, // R2 red
    {4'd2,  5'h04, 4'h1, 32'h0000_0022, 8'h10, 24'h112200, 1'b1}, // R2 green
    {4'd3,  5'h04, 4'h1, 32'h0000_0033, 8'h10, 24'h112233, 1'b1}, // R3 blue then advance
    {4'd4,  5'h04, 4'hF, 32'hAABB_CCDD, 8'h11, 24'hAABBCC, 1'b1}, // R4 from red
    {4'd4,  5'h04, 4'hF, 32'h0102_0304, 8'h12, 24'hDD0102, 1'b1}, // R4 from green
    {4'd4,  5'h04, 4'hF, 32'h0506_0708, 8'h13, 24'h030405, 1'b1}, // R4 from blue
    {4'd5,  5'h04, 4'h3, 32'hEEEE_EEEE, 8'h14, 24'h060708, 1'b0}, // R5 odd width
    {4'd5,  5'h04, 4'h1, 32'h0000_0099, 8'h15, 24'h990000, 1'b1}, // R5 phase untouched
    {4'd1,  5'h00, 4'h1, 32'h0000_00FF, 8'hFF, 24'h000000, 1'b0}, // R1 byte-form pointer
    {4'd3,  5'h04, 4'hF, 32'h4142_4344, 8'hFF, 24'h414243, 1'b1}, // R3 wrap 0xFF
    {4'd5,  5'h08, 4'hF, 32'h1234_5678, 8'h00, 24'h440000, 1'b0}, // R5 unused offset
    {4'd1,  5'h00, 4'h1, 32'h0000_0020, 8'h20, 24'h000000, 1'b0}, // R1 phase back to red
    {4'd1,  5'h04, 4'h1, 32'h0000_005A, 8'h20, 24'h5A0000, 1'b1}  // R1 red after reload
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic look(input logic [7:0] i, output logic [23:0] v);
    pix_idx = i;
    @(negedge clk);
    v = pix_rgb;
  endtask

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle after reset", 32'(redraw), 0);
    chk("R6 read data", bus_rdata, 0);
    look(8'h10, v); chk("R7 initial entry", 32'(v), 0);
    look(8'hFF, v); chk("R7 initial entry", 32'(v), 0);

    for (int n = 0; n < NV; n++) begin
      bus_wr(VEC[n][73:69], VEC[n][68:65], VEC[n][64:33]);
      chk($sformatf("R10 pulse vec %0d", n), 32'(redraw), 32'(VEC[n][0]));
      look(VEC[n][32:25], v);
      chk($sformatf("R%0d vec %0d", VEC[n][77:74], n), 32'(v), 32'(VEC[n][24:1]));
      chk("R10 pulse ends", 32'(redraw), 0);
    end

    // R9 collision: write red of 0x30 while looking it up
    bus_wr(5'h00, 4'hF, 32'h30);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h04; bus_be = 4'h1; bus_wdata = 32'hC3;
    pix_idx = 8'h30;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
    chk("R9 old value on collision", 32'(pix_rgb), 0);
    chk("R10 collision pulse", 32'(redraw), 1);
    @(negedge clk);
    chk("R8 new value next cycle", 32'(pix_rgb), 32'h00C30000);
    chk("R6 read data after writes", bus_rdata, 0);

    // leave the sequence mid-entry, then reset
    bus_wr(5'h00, 4'h1, 32'h50);
    bus_wr(5'h04, 4'h1, 32'h01);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 256; i++) begin
      look(8'(i), v);
      chk($sformatf("R7 cleared entry %0d", i), 32'(v), 0);
    end
    bus_wr(5'h04, 4'h1, 32'h66);
    look(8'h00, v); chk("R7 pointer 0 phase red", 32'(v), 32'h00660000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule